// File: doc/BRIEF.md
# Address Range Fault Detector

This block sits beside a processor core's load/store path and flags any memory access whose address lands outside every legal segment of the application's address space. Software programs up to three segment windows: static data, heap and stack. Each window is a base/limit pair with its own enable. The hardware only enforces the windows that software has set. An access that matches no enabled window is treated as a sign that the hardware has gone wrong. It is not treated as a program bug.

The check is purely observational. Each request is compared against all windows in parallel in the cycle it is presented. A violation is reported one clock later as a single-cycle symptom pulse that carries the offending address and whether it was a load or a store. The first violation is also held in a sticky record until software clears it. The request stream is never stalled. A global enable lets software switch checking off, for example while the windows are being rewritten.

Top module: `addr_guard`

## Requirements
- R1: After reset, every window is disabled with zero bounds, global checking is off, and sym_pulse and stk_valid are 0.
- R2: An address is legal when, for at least one enabled window, base <= addr < limit. Both bounds are compared as unsigned values: the base is inclusive and the limit is exclusive.
- R3: A request with req_valid=1 whose address is not legal, made while global checking is on, makes sym_pulse=1 on the following cycle. In that cycle sym_addr holds the request address and sym_is_store holds the access kind (1 = store, 0 = load).
- R4: A window whose enable bit is 0 never makes an address legal.
- R5: While global checking is off, no request raises sym_pulse or changes the sticky record.
- R6: A cycle with req_valid=0 never raises sym_pulse, whatever the address.
- R7: A window write (cfg_wr=1) sets the base, limit and enable of window cfg_idx together at the clock edge. A global-enable write (glb_wr=1) likewise takes effect at the edge. A request in the same cycle as either write is judged with the old values.
- R8: The first violation sets stk_valid=1 and records its address and kind in stk_addr and stk_is_store. Later violations leave that record unchanged until it is cleared.
- R9: stk_clr=1 drops stk_valid on the next cycle. If a violation arrives in the same cycle as the clear, the sticky record takes that new violation instead.
- R10: A window with base >= limit matches no address.
- R11: A window write to an index at or above the window count (index 3 with three windows) changes no window.
- R12: Requests are accepted every cycle with no stall. Violations on consecutive cycles give sym_pulse on consecutive cycles, each with its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write one window this cycle |
| cfg_idx | input | 2 | Window index to write |
| cfg_base | input | ADDR_W | New inclusive lower bound |
| cfg_limit | input | ADDR_W | New exclusive upper bound |
| cfg_on | input | 1 | New window enable |
| glb_wr | input | 1 | Write the global enable this cycle |
| glb_on | input | 1 | New global enable value |
| req_valid | input | 1 | A load or store is presented |
| req_addr | input | ADDR_W | Access address |
| req_is_store | input | 1 | 1 = store, 0 = load |
| stk_clr | input | 1 | Clear the sticky record |
| sym_pulse | output | 1 | One-cycle violation symptom |
| sym_addr | output | ADDR_W | Address of the violating access |
| sym_is_store | output | 1 | Kind of the violating access |
| stk_valid | output | 1 | Sticky record holds a violation |
| stk_addr | output | ADDR_W | Recorded violating address |
| stk_is_store | output | 1 | Recorded access kind |

## Verification
The bench builds the block with its defaults: 32-bit addresses and three windows addressed by a 2-bit index. Because the index is 2 bits wide and only three windows exist, index 3 is one index past the last window, so the ignored-write case can be driven through the normal port. The 32-bit width lets the bench place windows at the bottom, middle and high end of the space and probe the exact base, base-1, limit-1 and limit addresses of each one.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;

    // Access kind as carried on req_is_store / sym_is_store
    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_e;

    // Widest address the window helper accepts
    localparam int unsigned AG_MAX_W = 64;

    // Captured violation descriptor (address carried separately)
    typedef struct packed {
        logic      valid;
        acc_kind_e kind;
    } sym_flags_t;

    // Half-open window test; an inverted or empty window matches nothing
    function automatic logic window_hit(
        input logic [AG_MAX_W-1:0] base,
        input logic [AG_MAX_W-1:0] limit,
        input logic [AG_MAX_W-1:0] addr
    );
        return (addr >= base) && (addr < limit);
    endfunction

endpackage

// File: rtl/ag_bound_bank.sv
module ag_bound_bank
    import addr_guard_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned NUM_REGIONS = 3,
    parameter int unsigned IDX_W       = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cfg_wr,
    input  logic [IDX_W-1:0]                    cfg_idx,
    input  logic [ADDR_W-1:0]                   cfg_base,
    input  logic [ADDR_W-1:0]                   cfg_limit,
    input  logic                                cfg_on,
    input  logic                                glb_wr,
    input  logic                                glb_on,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]  base_q,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]  limit_q,
    output logic [NUM_REGIONS-1:0]              on_q,
    output logic                                glb_q
);

    // One register set per window; a pair is rewritten in a single edge
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                on_q[g]    <= 1'b0;
            end else if (cfg_wr && (cfg_idx == IDX_W'(g))) begin
                base_q[g]  <= cfg_base;
                limit_q[g] <= cfg_limit;
                on_q[g]    <= cfg_on;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            glb_q <= 1'b0;
        else if (glb_wr)
            glb_q <= glb_on;
    end

endmodule

// File: rtl/ag_range_cmp.sv
module ag_range_cmp
    import addr_guard_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned NUM_REGIONS = 3
) (
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] limit_q,
    input  logic [NUM_REGIONS-1:0]             on_q,
    input  logic [ADDR_W-1:0]                  addr,
    output logic                               legal
);

    logic [NUM_REGIONS-1:0] hit;

    // All windows compared side by side in the request cycle
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        always_comb begin
            hit[g] = on_q[g] && window_hit(AG_MAX_W'(base_q[g]),
                                           AG_MAX_W'(limit_q[g]),
                                           AG_MAX_W'(addr));
        end
    end

    assign legal = |hit;

endmodule

// File: rtl/ag_symptom.sv
module ag_symptom
    import addr_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_store,
    input  logic              legal,
    input  logic              glb_q,
    input  logic              stk_clr,
    output logic              sym_pulse,
    output logic [ADDR_W-1:0] sym_addr,
    output logic              sym_is_store,
    output logic              stk_valid,
    output logic [ADDR_W-1:0] stk_addr,
    output logic              stk_is_store
);

    logic       violation;
    sym_flags_t now_f, pulse_f, stk_f;

    assign violation = req_valid && glb_q && !legal;

    always_comb begin
        now_f.valid = violation;
        now_f.kind  = req_is_store ? ACC_STORE : ACC_LOAD;
    end

    // Single-cycle symptom pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_f  <= '{valid: 1'b0, kind: ACC_LOAD};
            sym_addr <= '0;
        end else begin
            pulse_f <= now_f;
            if (violation)
                sym_addr <= req_addr;
        end
    end

    // Sticky record: first violation wins; a clear reopens it, and a
    // violation arriving with the clear is captured at once
    always_ff @(posedge clk) begin
        if (rst) begin
            stk_f    <= '{valid: 1'b0, kind: ACC_LOAD};
            stk_addr <= '0;
        end else if (violation && (stk_clr || !stk_f.valid)) begin
            stk_f    <= now_f;
            stk_addr <= req_addr;
        end else if (stk_clr) begin
            stk_f.valid <= 1'b0;
        end
    end

    assign sym_pulse    = pulse_f.valid;
    assign sym_is_store = (pulse_f.kind == ACC_STORE);
    assign stk_valid    = stk_f.valid;
    assign stk_is_store = (stk_f.kind == ACC_STORE);

endmodule

// File: rtl/addr_guard.sv
module addr_guard
    import addr_guard_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned NUM_REGIONS = 3,
    localparam int unsigned IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic              cfg_on,
    input  logic              glb_wr,
    input  logic              glb_on,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_store,
    input  logic              stk_clr,
    output logic              sym_pulse,
    output logic [ADDR_W-1:0] sym_addr,
    output logic              sym_is_store,
    output logic              stk_valid,
    output logic [ADDR_W-1:0] stk_addr,
    output logic              stk_is_store
);

    logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0] limit_q;
    logic [NUM_REGIONS-1:0]             on_q;
    logic                               glb_q;
    logic                               legal;

    ag_bound_bank #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_on(cfg_on),
        .glb_wr(glb_wr), .glb_on(glb_on),
        .base_q(base_q), .limit_q(limit_q), .on_q(on_q), .glb_q(glb_q)
    );

    ag_range_cmp #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)
    ) u_cmp (
        .base_q(base_q), .limit_q(limit_q), .on_q(on_q),
        .addr(req_addr), .legal(legal)
    );

    ag_symptom #(
        .ADDR_W(ADDR_W)
    ) u_sym (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_is_store(req_is_store),
        .legal(legal), .glb_q(glb_q), .stk_clr(stk_clr),
        .sym_pulse(sym_pulse), .sym_addr(sym_addr), .sym_is_store(sym_is_store),
        .stk_valid(stk_valid), .stk_addr(stk_addr), .stk_is_store(stk_is_store)
    );

endmodule

// File: rtl/ag_checker.sv
module ag_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_is_store,
    input logic              stk_clr,
    input logic              glb_q,
    input logic              sym_pulse,
    input logic [ADDR_W-1:0] sym_addr,
    input logic              sym_is_store,
    input logic              stk_valid,
    input logic [ADDR_W-1:0] stk_addr
);

    AST_PULSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        sym_pulse |-> $past(req_valid)); // R6

    AST_PULSE_NEEDS_GLB: assert property (@(posedge clk) disable iff (rst)
        sym_pulse |-> $past(glb_q)); // R5

    AST_PULSE_ADDR: assert property (@(posedge clk) disable iff (rst)
        sym_pulse |-> (sym_addr == $past(req_addr))); // R3

    AST_PULSE_KIND: assert property (@(posedge clk) disable iff (rst)
        sym_pulse |-> (sym_is_store == $past(req_is_store))); // R3

    AST_PULSE_SETS_STICKY: assert property (@(posedge clk) disable iff (rst)
        sym_pulse |-> stk_valid); // R8

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(stk_valid) && !$past(stk_clr)) |-> (stk_valid && $stable(stk_addr))); // R8

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        ($past(stk_clr) && !sym_pulse) |-> !stk_valid); // R9

endmodule

bind addr_guard ag_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_is_store(req_is_store),
    .stk_clr(stk_clr), .glb_q(glb_q),
    .sym_pulse(sym_pulse), .sym_addr(sym_addr), .sym_is_store(sym_is_store),
    .stk_valid(stk_valid), .stk_addr(stk_addr)
);

// File: tb/tb_addr_guard.sv
module tb_addr_guard;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_wr, cfg_on, glb_wr, glb_on;
    logic [1:0]    cfg_idx;
    logic [AW-1:0] cfg_base, cfg_limit;
    logic          req_valid, req_is_store, stk_clr;
    logic [AW-1:0] req_addr;
    logic          sym_pulse, sym_is_store, stk_valid, stk_is_store;
    logic [AW-1:0] sym_addr, stk_addr;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_guard #(.ADDR_W(AW), .NUM_REGIONS(3)) dut (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_on(cfg_on),
        .glb_wr(glb_wr), .glb_on(glb_on),
        .req_valid(req_valid), .req_addr(req_addr), .req_is_store(req_is_store),
        .stk_clr(stk_clr),
        .sym_pulse(sym_pulse), .sym_addr(sym_addr), .sym_is_store(sym_is_store),
        .stk_valid(stk_valid), .stk_addr(stk_addr), .stk_is_store(stk_is_store)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Program one window; caller is at a negedge, returns at the next one
    task automatic set_win(input logic [1:0] idx, input logic [AW-1:0] b,
                           input logic [AW-1:0] l, input logic on);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_base = b; cfg_limit = l; cfg_on = on;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_glb(input logic on);
        glb_wr = 1'b1; glb_on = on;
        @(negedge clk);
        glb_wr = 1'b0;
    endtask

    // Present one request and check the symptom one cycle later
    task automatic access(input logic [AW-1:0] a, input logic st,
                          input logic exp_fault, input string tag);
        req_valid = 1'b1; req_addr = a; req_is_store = st;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " pulse"}, 64'(sym_pulse), 64'(exp_fault));
        if (exp_fault) begin
            check({tag, " addr"}, 64'(sym_addr), 64'(a));
            check({tag, " kind"}, 64'(sym_is_store), 64'(st));
        end
    endtask

    task automatic t_reset;
        check("R1 pulse", 64'(sym_pulse), 64'd0);
        check("R1 sticky", 64'(stk_valid), 64'd0);
    endtask

    task automatic t_global_off;
        access(32'hDEAD_0000, 1'b1, 1'b0, "R5 off at reset");
        set_win(2'd0, 32'h0000_1000, 32'h0000_2000, 1'b1);
        set_win(2'd1, 32'h0001_0000, 32'h0002_0000, 1'b1);
        set_win(2'd2, 32'h7000_0000, 32'h7001_0000, 1'b1);
        access(32'h0000_0004, 1'b0, 1'b0, "R5 bounds set, still off");
        check("R5 sticky untouched", 64'(stk_valid), 64'd0);
        set_glb(1'b1);
    endtask

    task automatic t_legal;
        access(32'h0000_1000, 1'b0, 1'b0, "R2 glob base");
        access(32'h0000_1FFF, 1'b1, 1'b0, "R2 glob limit-1");
        access(32'h0001_0000, 1'b1, 1'b0, "R2 heap base");
        access(32'h0001_FFFF, 1'b0, 1'b0, "R2 heap limit-1");
        access(32'h7000_0000, 1'b1, 1'b0, "R2 stack base");
        access(32'h7000_FFFF, 1'b1, 1'b0, "R2 stack limit-1");
        access(32'h0000_2000, 1'b0, 1'b1, "R3 glob limit load");
        access(32'h0000_0FFF, 1'b1, 1'b1, "R3 glob base-1 store");
        access(32'h7001_0000, 1'b1, 1'b1, "R3 stack limit store");
    endtask

    task automatic t_sticky;
        check("R8 first kept valid", 64'(stk_valid), 64'd1);
        check("R8 first kept addr", 64'(stk_addr), 64'h0000_2000);
        check("R8 first kept kind", 64'(stk_is_store), 64'd0);
        stk_clr = 1'b1;
        @(negedge clk);
        stk_clr = 1'b0;
        check("R9 cleared", 64'(stk_valid), 64'd0);
        access(32'h0000_0005, 1'b1, 1'b1, "R8 new first");
        access(32'h0000_0009, 1'b0, 1'b1, "R8 second");
        check("R8 holds first addr", 64'(stk_addr), 64'h0000_0005);
        check("R8 holds first kind", 64'(stk_is_store), 64'd1);
        stk_clr = 1'b1;
        access(32'h0300_0000, 1'b0, 1'b1, "R9 clear+violation");
        stk_clr = 1'b0;
        check("R9 takes new valid", 64'(stk_valid), 64'd1);
        check("R9 takes new addr", 64'(stk_addr), 64'h0300_0000);
    endtask

    task automatic t_disable;
        set_win(2'd1, 32'h0001_0000, 32'h0002_0000, 1'b0);
        access(32'h0001_8000, 1'b0, 1'b1, "R4 heap disabled");
        set_win(2'd1, 32'h0001_0000, 32'h0002_0000, 1'b1);
        access(32'h0001_8000, 1'b0, 1'b0, "R4 heap re-enabled");
    endtask

    task automatic t_same_cycle;
        cfg_wr = 1'b1; cfg_idx = 2'd0; cfg_on = 1'b1;
        cfg_base = 32'h0000_3000; cfg_limit = 32'h0000_4000;
        access(32'h0000_1800, 1'b0, 1'b0, "R7 old bounds used");
        cfg_wr = 1'b0;
        access(32'h0000_1800, 1'b0, 1'b1, "R7 old window gone");
        access(32'h0000_3800, 1'b1, 1'b0, "R7 new window live");
        glb_wr = 1'b1; glb_on = 1'b0;
        access(32'h0500_0000, 1'b1, 1'b1, "R7 glb off same cycle");
        glb_wr = 1'b0;
        access(32'h0500_0000, 1'b1, 1'b0, "R7 glb off applied");
        set_glb(1'b1);
    endtask

    task automatic t_empty;
        set_win(2'd0, 32'h0000_5000, 32'h0000_5000, 1'b1);
        access(32'h0000_5000, 1'b0, 1'b1, "R10 base==limit");
        set_win(2'd0, 32'h0000_6000, 32'h0000_5000, 1'b1);
        access(32'h0000_5800, 1'b0, 1'b1, "R10 base>limit");
    endtask

    task automatic t_bad_idx;
        set_win(2'd3, 32'h9000_0000, 32'hA000_0000, 1'b1);
        access(32'h9000_0000, 1'b1, 1'b1, "R11 idx3 ignored");
        access(32'h7000_0010, 1'b0, 1'b0, "R11 stack intact");
    endtask

    task automatic t_valid_low;
        req_valid = 1'b0; req_addr = 32'hFFFF_FFF0; req_is_store = 1'b1;
        @(negedge clk);
        check("R6 no request", 64'(sym_pulse), 64'd0);
    endtask

    task automatic t_b2b;
        access(32'h0800_0000, 1'b0, 1'b1, "R12 first");
        access(32'h0800_0004, 1'b1, 1'b1, "R12 second");
        access(32'h0001_0004, 1'b0, 1'b0, "R12 legal after");
    endtask

    initial begin
        rst = 1'b1;
        cfg_wr = 0; cfg_idx = 0; cfg_base = 0; cfg_limit = 0; cfg_on = 0;
        glb_wr = 0; glb_on = 0;
        req_valid = 0; req_addr = 0; req_is_store = 0; stk_clr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_global_off();
        t_legal();
        t_sticky();
        t_disable();
        t_same_cycle();
        t_empty();
        t_bad_idx();
        t_valid_low();
        t_b2b();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule